// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz time-base tick into a periodic pulse at one of fifteen selectable rates. It raises a sticky interrupt flag on each pulse. Two byte-wide control registers and one flag register sit behind a small addressed read/write bus. The control registers configure the block and report its state.

The first control register holds three fields. A 4-bit rate code selects the pulse rate. A 3-bit divider code starts or stops the prescaler chain. A read-only update-in-progress bit toggles on every read of that register. The second control register is a plain byte. Its bit 6 gates the interrupt line, and its other bits are stored and read back only. The flag register reports the sticky flag and clears it when it is read.

The rate map is irregular. Codes 1 and 2 give 256 Hz and 128 Hz. From code 3 upwards, each code halves the rate. Code 0 switches the output off. The prescaler runs only with the 32768 Hz divider code. Every other divider code holds the prescaler at zero.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, register A (address 0x0A) holds divider code 2, rate code 6 and update-in-progress 0, so its stored value is 0x26. Register B (0x0B) holds 0x42. The flag is clear, and pulse_o, irq_o and rdata_o are low.
- R2: A read (sel_i=1, wr_i=0) returns its byte on rdata_o one cycle later. rdata_o is 0x00 in every cycle that does not follow a read. Register B returns the last byte written to it. Any address other than 0x0A, 0x0B and 0x0C reads as 0x00, and a write to such an address changes nothing.
- R3: Bit 7 of register A (update-in-progress) cannot be written. A write to A stores only bits 6:4 (divider code) and 3:0 (rate code). Each read of A inverts the bit and returns the inverted value.
- R4: With divider code 2, rate code 1 gives one pulse every 128 ticks (256 Hz). Rate code 2 gives one pulse every 256 ticks (128 Hz).
- R5: With divider code 2, rate code n from 3 to 15 gives one pulse every 2^(n-1) ticks. Code 6 therefore gives 32 ticks (1024 Hz).
- R6: Rate code 0 produces no pulses.
- R7: Any divider code other than 2 holds the prescaler at zero and produces no pulses. This includes the disable codes 6 and 7 and the unsupported codes 0, 1, 3, 4 and 5. When code 2 is written again, the first pulse follows after exactly one full period of ticks.
- R8: pulse_o is high for one cycle at a time. The period counts only cycles in which tick_i is high.
- R9: Each pulse sets the flag, which reads as bit 6 of the flag register at 0x0C. A read of 0x0C clears the flag unless a pulse arrives in the same cycle. Writes to 0x0C are ignored.
- R10: irq_o is high exactly when the flag is set and register B bit 6 is set. Clearing bit 6 masks irq_o but does not stop the pulses or the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 32768 Hz time-base enable, one cycle per tick |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| pulse_o | output | 1 | One-cycle periodic pulse |
| irq_o | output | 1 | Periodic interrupt line |

## Verification
The assertions assume that all inputs change only between clock edges and that each bus access is a single strobed cycle, either a read or a write. They also assume tick_i is a synchronous enable sampled at the same edges as the bus. The stimulus drives every input at the falling edge or shortly after a rising edge. The stimulus holds tick_i high, toggles it every cycle, or holds it low. Low tick freezes the prescaler so that the flag and interrupt checks run without a pulse arriving in the middle.

// File: rtl/pirg_pkg.sv
package pirg_pkg;

  typedef struct packed {
    logic       uip;
    logic [2:0] dv;
    logic [3:0] rs;
  } ctrl_a_t;

  typedef struct packed {
    logic halt;
    logic pie;
    logic aie;
    logic uie;
    logic sqwe;
    logic bin;
    logic hr24;
    logic dse;
  } ctrl_b_t;

  localparam logic [2:0] DV_RUN       = 3'd2;
  localparam logic [3:0] RS_OFF       = 4'd0;
  localparam logic [3:0] RS_DEFAULT   = 4'd6;
  localparam logic [7:0] CTRL_B_RESET = 8'h42;
  localparam int         FLAG_BIT     = 6;

endpackage

// File: rtl/pirg_rate_map.sv
module pirg_rate_map
  import pirg_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic [3:0]       rs_i,
  output logic             en_o,
  output logic [CNT_W-1:0] mask_o
);

  logic [4:0] shift;

  // codes 1 and 2 break the power-of-two rule
  always_comb begin
    unique case (rs_i)
      4'd1:    shift = 5'd7;
      4'd2:    shift = 5'd8;
      default: shift = {1'b0, rs_i} - 5'd1;
    endcase
  end

  assign en_o = (rs_i != RS_OFF);

  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask_o[g] = (5'(g) < shift);
  end

endmodule

// File: rtl/pirg_prescaler.sv
module pirg_prescaler #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             pulse_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = ((cnt_q & mask_i) == mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= run_i && en_i && tick_i && wrap;
      if (!run_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  assert_pulse_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(tick_i));
  assert_quiet_halted_R7: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !pulse_o);
  assert_quiet_off_R6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pulse_o);

endmodule

// File: rtl/pirg_regs.sv
module pirg_regs
  import pirg_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 'h0A,
  parameter logic [ADDR_W-1:0] ADDR_B = 'h0B,
  parameter logic [ADDR_W-1:0] ADDR_C = 'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              pulse_i,
  output ctrl_a_t           ctrl_a_o,
  output ctrl_b_t           ctrl_b_o,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);

  logic    rd, wr, hit_a, hit_b, hit_c;
  logic    flag_q;
  logic [7:0] rd_mux;

  assign rd    = sel_i & ~wr_i;
  assign wr    = sel_i & wr_i;
  assign hit_a = (addr_i == ADDR_A);
  assign hit_b = (addr_i == ADDR_B);
  assign hit_c = (addr_i == ADDR_C);

  always_comb begin
    rd_mux = 8'h00;
    if (hit_a)      rd_mux = {~ctrl_a_o.uip, ctrl_a_o.dv, ctrl_a_o.rs};
    else if (hit_b) rd_mux = ctrl_b_o;
    else if (hit_c) rd_mux[FLAG_BIT] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_a_o <= '{uip: 1'b0, dv: DV_RUN, rs: RS_DEFAULT};
      ctrl_b_o <= ctrl_b_t'(CTRL_B_RESET);
      flag_q   <= 1'b0;
      rdata_o  <= 8'h00;
    end else begin
      if (wr && hit_a) begin
        ctrl_a_o.dv <= wdata_i[6:4];
        ctrl_a_o.rs <= wdata_i[3:0];
      end
      if (rd && hit_a) ctrl_a_o.uip <= ~ctrl_a_o.uip;
      if (wr && hit_b) ctrl_b_o <= ctrl_b_t'(wdata_i);
      if (pulse_i)             flag_q <= 1'b1;
      else if (rd && hit_c)    flag_q <= 1'b0;
      rdata_o <= rd ? rd_mux : 8'h00;
    end
  end

  assign irq_o = flag_q & ctrl_b_o.pie;

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> flag_q);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && hit_c && !pulse_i) |=> !flag_q);
  assert_uip_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd && hit_a) |=> $stable(ctrl_a_o.uip));
  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata_o == 8'h00));

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pirg_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] ADDR_A  = 'h0A,
  parameter logic [ADDR_W-1:0] ADDR_B  = 'h0B,
  parameter logic [ADDR_W-1:0] ADDR_C  = 'h0C,
  parameter int                TB_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              pulse_o,
  output logic              irq_o
);

  localparam int CNT_W = TB_LOG2 - 1;

  ctrl_a_t          ctrl_a;
  ctrl_b_t          ctrl_b;
  logic             rate_en;
  logic [CNT_W-1:0] rate_mask;
  logic             run;

  assign run = (ctrl_a.dv == DV_RUN);

  pirg_regs #(
    .ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .ADDR_C(ADDR_C)
  ) regs_i (
    .clk(clk), .rst(rst), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .pulse_i(pulse_o), .ctrl_a_o(ctrl_a),
    .ctrl_b_o(ctrl_b), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  pirg_rate_map #(.CNT_W(CNT_W)) map_i (
    .rs_i(ctrl_a.rs), .en_o(rate_en), .mask_o(rate_mask)
  );

  pirg_prescaler #(.CNT_W(CNT_W)) pre_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run), .en_i(rate_en),
    .mask_i(rate_mask), .pulse_o(pulse_o)
  );

endmodule

// File: tb/periodic_irq_gen_tb_top.sv
`timescale 1ns/1ps
module periodic_irq_gen_tb_top;

  logic       clk = 1'b0, rst = 1'b1, tick_i = 1'b1, sel_i = 1'b0, wr_i = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
  logic [7:0] rdata_o, rv;
  logic       pulse_o, irq_o;
  int         checks = 0, fails = 0, t;

  periodic_irq_gen dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pulse_o(pulse_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); sel_i = 0; wr_i = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sel_i = 1; wr_i = 0; addr_i = a;
    @(negedge clk); sel_i = 0; d = rdata_o;
  endtask

  task automatic measure(input bit alt, output int ticks);
    ticks = 0;
    for (int c = 0; c < 40000; c++) begin
      @(posedge clk);
      if (tick_i) ticks++;
      #1;
      if (pulse_o) return;
      if (alt) tick_i = ~tick_i;
    end
    ticks = -1;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      if (pulse_o) cnt++;
    end
  endtask

  function automatic int period(input int n);
    if (n == 1) return 128;
    if (n == 2) return 256;
    return 1 << (n - 1);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 pulse", int'(pulse_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 rdata", int'(rdata_o), 0);
    bus_rd(8'h0A, rv); chk("R1 R3 first A read", rv, 8'hA6);
    bus_rd(8'h0A, rv); chk("R1 second A read", rv, 8'h26);
    bus_rd(8'h0B, rv); chk("R1 B reset", rv, 8'h42);

    // R3: uip is 1 after this read; a write of 0 to bit 7 must not land
    bus_rd(8'h0A, rv); chk("R3 toggle", rv, 8'hA6);
    bus_wr(8'h0A, 8'h26);
    bus_rd(8'h0A, rv); chk("R3 uip not writable", rv, 8'h26);

    // R2
    bus_wr(8'h0B, 8'h3D);
    bus_rd(8'h0B, rv); chk("R2 B readback", rv, 8'h3D);
    bus_wr(8'h0D, 8'hFF);
    bus_rd(8'h0B, rv); chk("R2 unmapped write", rv, 8'h3D);
    bus_rd(8'h0D, rv); chk("R2 unmapped read", rv, 0);
    bus_rd(8'h00, rv); chk("R2 unmapped read 0", rv, 0);
    @(posedge clk); #1; chk("R2 idle rdata", int'(rdata_o), 0);
    bus_wr(8'h0B, 8'h42);

    // R4 R5: every rate code from a zeroed prescaler
    for (int n = 1; n < 16; n++) begin
      bus_wr(8'h0A, 8'(8'h60 | n));
      repeat (3) @(posedge clk);
      bus_wr(8'h0A, 8'(8'h20 | n));
      measure(0, t); chk(n < 3 ? "R4 first period" : "R5 first period", t, period(n));
      measure(0, t); chk(n < 3 ? "R4 next period" : "R5 next period", t, period(n));
    end

    // R6
    bus_wr(8'h0A, 8'h20);
    repeat (3) @(posedge clk);
    count_pulses(600, t); chk("R6 code 0 silent", t, 0);

    // R7
    foreach (t_dv[i]) begin end
    for (int d = 0; d < 8; d++) begin
      if (d == 2) continue;
      bus_wr(8'h0A, 8'((d << 4) | 6));
      repeat (3) @(posedge clk);
      count_pulses(200, t); chk("R7 held divider silent", t, 0);
      bus_wr(8'h0A, 8'h26);
      measure(0, t); chk("R7 restart from zero", t, 32);
    end

    // R8: alternate ticks, period counted in ticks, one-cycle pulse
    bus_wr(8'h0A, 8'h63);
    repeat (3) @(posedge clk);
    bus_wr(8'h0A, 8'h23);
    measure(1, t); chk("R8 gated first period", t, 4);
    measure(1, t); chk("R8 gated next period", t, 4);
    @(posedge clk); #1; chk("R8 single cycle pulse", int'(pulse_o), 0);
    tick_i = 1;

    // R9 R10
    bus_wr(8'h0A, 8'h66);
    repeat (3) @(posedge clk);
    bus_wr(8'h0A, 8'h26);
    measure(0, t);
    tick_i = 0;
    @(posedge clk); #1; chk("R10 irq set", int'(irq_o), 1);
    bus_wr(8'h0C, 8'h00); chk("R9 write C ignored", int'(irq_o), 1);
    bus_rd(8'h0C, rv); chk("R9 flag read", rv, 8'h40);
    chk("R9 read clears irq", int'(irq_o), 0);
    bus_rd(8'h0C, rv); chk("R9 flag cleared", rv, 0);

    bus_wr(8'h0B, 8'h02);
    tick_i = 1;
    measure(0, t);
    tick_i = 0;
    @(posedge clk); #1; chk("R10 masked irq", int'(irq_o), 0);
    bus_wr(8'h0B, 8'h42); chk("R10 unmask irq", int'(irq_o), 1);
    bus_rd(8'h0C, rv); chk("R10 flag kept while masked", rv, 8'h40);
    chk("R9 irq after clear", int'(irq_o), 0);

    summary();
    $finish;
  end

  int t_dv[1];

endmodule